// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block provides the port-to-port signalling for a two-ported word memory of 2K locations. It watches the address, enable, write and output-enable inputs of a left and a right port. It keeps one latched, active-low interrupt line for each port. The two highest addresses of the array act as mailboxes:

- A left-port write to the top address raises the right port's interrupt.
- A right-port write to the address one below the top raises the left port's interrupt.
- The receiving port drops its own interrupt by reading the mailbox that targets it.

Message bytes are stored in an ordinary behavioural array, so the receiver finds the payload at the same location that signalled it. All strobes are sampled on the rising clock edge, and every effect of an access is visible after that edge.

Each interrupt flag is a two-state machine. In state `MBX_EMPTY` the line is high. In state `MBX_FULL` the line is low. The transitions are:

- `POST`: a set event moves EMPTY to FULL.
- `HOLD`: while FULL with no clearing read, or with a set arriving, the state stays FULL.
- `TAKE`: a clearing read with no coincident set moves FULL to EMPTY.
- `IDLE`: while EMPTY with no set, the state stays EMPTY.

Reset forces both machines to `MBX_EMPTY`.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it, both `l_irq_n` and `r_irq_n` are 1.
- R2: A left access with `l_en`=1, `l_wr`=1 and `l_addr`=0x7FF drives `r_irq_n` to 0 after that clock edge.
- R3: A right access with `r_en`=1, `r_wr`=1 and `r_addr`=0x7FE drives `l_irq_n` to 0 after that clock edge.
- R4: A right read (`r_en`=1, `r_wr`=0, `r_oe`=1) of 0x7FF returns `r_irq_n` to 1. A left read of 0x7FE with the same strobe values returns `l_irq_n` to 1.
- R5: A write needs enable and write both at 1. With `l_wr`=1 and `l_en`=0 at 0x7FF, no flag changes and the array is not written.
- R6: A read with `r_oe`=0 (`r_en`=1, `r_wr`=0) of 0x7FF leaves `r_irq_n` at 0.
- R7: A flag that is set stays set across any access other than its own clearing read.
- R8: When a set and a clear of the same flag fall on the same edge, the flag ends set (interrupt line 0).
- R9: Accesses to any address other than 0x7FE and 0x7FF change neither flag.
- R10: A port writing its own receive mailbox (left 0x7FE, right 0x7FF) or reading its own send mailbox (left 0x7FF, right 0x7FE) changes no flag.
- R11: Data written by one port is returned on the other port's read data one clock after a read with enable=1 and write=0.
- R12: When both ports write the same address on the same edge, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Active-low synchronous reset of flags and read registers |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left write strobe, 1 = write, 0 = read |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right write strobe, 1 = write, 0 = read |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench goes after collisions where a set and a clear of one flag share an edge. A design that let the clear win would lose the message, and its line would read 1 where 0 is expected. It probes near-miss strobes: a write strobe without enable, and a read without output enable. A decoder that ignored either input would raise or drop a flag wrongly. It also probes the mirror cases where a port touches its own mailbox. A decoder with the two addresses swapped would show up there. Payload round-trips and a simultaneous write to one address check that the array's port priority and one-cycle read latency match the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        MBX_EMPTY = 1'b0,
        MBX_FULL  = 1'b1
    } mbx_state_e;
endpackage

// File: rtl/mbx_port_decode.sv
// Turns one port's strobes into a mailbox post (write of its send slot)
// and a mailbox take (qualified read of its receive slot).
module mbx_port_decode #(
    parameter int ADDR_W    = 11,
    parameter int SEND_ADDR = 2047,
    parameter int RECV_ADDR = 2046
) (
    input  logic              en,
    input  logic              wr,
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr,
    output logic              post,
    output logic              take
);
    localparam logic [ADDR_W-1:0] SEND_A = ADDR_W'(SEND_ADDR);
    localparam logic [ADDR_W-1:0] RECV_A = ADDR_W'(RECV_ADDR);

    always_comb begin
        post = en && wr && (addr == SEND_A);
        take = en && !wr && oe && (addr == RECV_A);
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
// One sticky interrupt flag. A set on the same edge as a clear wins.
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic irq_n
);
    mbx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MBX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MBX_EMPTY: if (set_ev) state_d = MBX_FULL;             // POST
            MBX_FULL:  if (clr_ev && !set_ev) state_d = MBX_EMPTY; // TAKE
            default:   state_d = MBX_EMPTY;
        endcase
    end

    always_comb begin
        irq_n = (state_q != MBX_FULL);
    end
endmodule

// File: rtl/mbx_store.sv
// Behavioural two-port array. Same-address writes on one edge keep the left data.
module mbx_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (r_we) cells[r_addr] <= r_wdata;
        if (l_we) cells[l_addr] <= l_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata <= '0;
            r_rdata <= '0;
        end else begin
            if (l_re) l_rdata <= cells[l_addr];
            if (r_re) r_rdata <= cells[r_addr];
        end
    end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_irq_n,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_irq_n
);
    localparam int TOP_SLOT  = (1 << ADDR_W) - 1;
    localparam int NEXT_SLOT = TOP_SLOT - 1;

    logic l_post, l_take, r_post, r_take;

    // Left sends through the top slot and receives through the one below it.
    mbx_port_decode #(.ADDR_W(ADDR_W), .SEND_ADDR(TOP_SLOT), .RECV_ADDR(NEXT_SLOT)) l_dec_i (
        .en(l_en), .wr(l_wr), .oe(l_oe), .addr(l_addr), .post(l_post), .take(l_take)
    );

    mbx_port_decode #(.ADDR_W(ADDR_W), .SEND_ADDR(NEXT_SLOT), .RECV_ADDR(TOP_SLOT)) r_dec_i (
        .en(r_en), .wr(r_wr), .oe(r_oe), .addr(r_addr), .post(r_post), .take(r_take)
    );

    mbx_flag_fsm to_right_i (
        .clk(clk), .rst_n(rst_n), .set_ev(l_post), .clr_ev(r_take), .irq_n(r_irq_n)
    );

    mbx_flag_fsm to_left_i (
        .clk(clk), .rst_n(rst_n), .set_ev(r_post), .clr_ev(l_take), .irq_n(l_irq_n)
    );

    mbx_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .l_we(l_en && l_wr), .l_re(l_en && !l_wr), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_we(r_en && r_wr), .r_re(r_en && !r_wr), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en,
    input logic              l_wr,
    input logic              l_oe,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_irq_n,
    input logic              r_en,
    input logic              r_wr,
    input logic              r_oe,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_irq_n
);
    localparam logic [ADDR_W-1:0] TOP_A  = '1;
    localparam logic [ADDR_W-1:0] NEXT_A = TOP_A - 1'b1;

    // R2
    left_post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_en && l_wr && l_addr == TOP_A) |=> !r_irq_n);

    // R3
    right_post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && r_wr && r_addr == NEXT_A) |=> !l_irq_n);

    // R4
    right_take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_en && !r_wr && r_oe && r_addr == TOP_A &&
         !(l_en && l_wr && l_addr == TOP_A)) |=> r_irq_n);

    // R7
    right_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_irq_n && !(r_en && !r_wr && r_oe && r_addr == TOP_A)) |=> !r_irq_n);

    // R7
    left_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_irq_n && !(l_en && !l_wr && l_oe && l_addr == NEXT_A)) |=> !l_irq_n);

    // R9
    right_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_irq_n && !(l_en && l_wr && l_addr == TOP_A)) |=> r_irq_n);
endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_top_tb.sv
module mbx_irq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 8;

    // control field: {en, wr, oe}
    localparam logic [2:0] IDL = 3'b000;
    localparam logic [2:0] WRT = 3'b110;
    localparam logic [2:0] RD  = 3'b101;
    localparam logic [2:0] RNO = 3'b100;
    localparam logic [2:0] WNE = 3'b010;

    typedef struct packed {
        logic [2:0]    lc;
        logic [AW-1:0] la;
        logic [2:0]    rc;
        logic [AW-1:0] ra;
        logic          el;
        logic          er;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{IDL, 11'h000, IDL, 11'h000, 1'b1, 1'b1, 4'd1},  // R1
        '{WRT, 11'h7FF, IDL, 11'h000, 1'b1, 1'b0, 4'd2},  // R2
        '{RD,  11'h7FE, IDL, 11'h000, 1'b1, 1'b0, 4'd7},  // R7
        '{IDL, 11'h000, WRT, 11'h100, 1'b1, 1'b0, 4'd9},  // R9
        '{IDL, 11'h000, RNO, 11'h7FF, 1'b1, 1'b0, 4'd6},  // R6
        '{IDL, 11'h000, RD,  11'h7FF, 1'b1, 1'b1, 4'd4},  // R4
        '{IDL, 11'h000, WRT, 11'h7FE, 1'b0, 1'b1, 4'd3},  // R3
        '{WRT, 11'h7FE, IDL, 11'h000, 1'b0, 1'b1, 4'd10}, // R10
        '{WNE, 11'h7FF, IDL, 11'h000, 1'b0, 1'b1, 4'd5},  // R5
        '{IDL, 11'h000, RD,  11'h7FE, 1'b0, 1'b1, 4'd10}, // R10
        '{RD,  11'h7FE, IDL, 11'h000, 1'b1, 1'b1, 4'd4},  // R4
        '{WRT, 11'h7FF, RD,  11'h7FF, 1'b1, 1'b0, 4'd8},  // R8
        '{RD,  11'h7FF, IDL, 11'h000, 1'b1, 1'b0, 4'd10}, // R10
        '{IDL, 11'h000, RD,  11'h7FF, 1'b1, 1'b1, 4'd4},  // R4
        '{RD,  11'h7FE, WRT, 11'h7FE, 1'b0, 1'b1, 4'd8},  // R8
        '{RD,  11'h7FE, IDL, 11'h000, 1'b1, 1'b1, 4'd4}   // R4
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] lc, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                         input logic [2:0] rc, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        {l_en, l_wr, l_oe} = lc;
        l_addr = la;
        l_wdata = ld;
        {r_en, r_wr, r_oe} = rc;
        r_addr = ra;
        r_wdata = rd;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 l_irq_n in reset", {7'd0, l_irq_n}, 8'd1);
        check("R1 r_irq_n in reset", {7'd0, r_irq_n}, 8'd1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].lc, VECS[i].la, 8'h11, VECS[i].rc, VECS[i].ra, 8'h22);
            check($sformatf("R%0d vec %0d l_irq_n", VECS[i].rq, i), {7'd0, l_irq_n}, {7'd0, VECS[i].el});
            check($sformatf("R%0d vec %0d r_irq_n", VECS[i].rq, i), {7'd0, r_irq_n}, {7'd0, VECS[i].er});
        end

        // R11: payload round trip through the right-bound mailbox
        drive(WRT, 11'h7FF, 8'hA5, IDL, '0, '0);
        drive(IDL, '0, '0, RD, 11'h7FF, '0);
        check("R11 right reads left payload", r_rdata, 8'hA5);
        check("R4 flag cleared after payload read", {7'd0, r_irq_n}, 8'd1);

        // R11: reverse direction, ordinary address
        drive(IDL, '0, '0, WRT, 11'h055, 8'h96);
        drive(RD, 11'h055, '0, IDL, '0, '0);
        check("R11 left reads right data", l_rdata, 8'h96);

        // R12: same-edge writes to one address
        drive(WRT, 11'h010, 8'h3C, WRT, 11'h010, 8'hC3);
        drive(IDL, '0, '0, RD, 11'h010, '0);
        check("R12 left data kept", r_rdata, 8'h3C);

        // R5: write strobe without enable leaves array untouched
        drive(WNE, 11'h010, 8'hFF, IDL, '0, '0);
        drive(RD, 11'h010, '0, IDL, '0, '0);
        check("R5 no write without enable", l_rdata, 8'h3C);
        check("R5 no flag without enable", {7'd0, r_irq_n}, 8'd1);

        // R1: reset drops pending flags
        drive(WRT, 11'h7FF, 8'h01, WRT, 11'h7FE, 8'h02);
        check("R2 pre-reset r flag", {7'd0, r_irq_n}, 8'd0);
        check("R3 pre-reset l flag", {7'd0, l_irq_n}, 8'd0);
        rst_n = 1'b0;
        drive(IDL, '0, '0, IDL, '0, '0);
        check("R1 l_irq_n after reset", {7'd0, l_irq_n}, 8'd1);
        check("R1 r_irq_n after reset", {7'd0, r_irq_n}, 8'd1);
        rst_n = 1'b1;
        drive(IDL, '0, '0, IDL, '0, '0);
        check("R1 l_irq_n first sample", {7'd0, l_irq_n}, 8'd1);
        check("R1 r_irq_n first sample", {7'd0, r_irq_n}, 8'd1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule